// File: doc/BRIEF.md
# Multimode Latched Parallel Port with Service Request

This block is an eight-bit parallel port with a data register, a selectable output enable and a service-request flag that drives an active-low interrupt. Two select pins form a single select term: one pin is active low and the other is active high. A mode pin decides two things. It chooses whether the data register loads from the select term or from a strobe pin. It also chooses whether the output is always driven or only while the port is selected. With the mode pin low and the strobe held high, the port behaves as a gated buffer. With the mode pin low and a pulsed strobe, it is a strobed input port that raises an interrupt. With the mode pin high, it is an output port that captures data when selected.

The design works in a single clock domain. Every pin arrives asynchronously and passes through a two-stage synchronizer before use. Strobe edges are found by comparing consecutive synchronized samples. A three-state output is represented as a data bus plus an enable flag, and the data bus reads zero whenever the flag is low.

Top module: `strobed_port`

## Requirements
- R1: The port counts as selected only while `sel_lo_n` is 0 and `sel_hi` is 1. Either of the other two combinations leaves it unselected.
- R2: With `mode`=1, `dout_oe` is 1 whether or not the port is selected. The register loads `din` while the port is selected and keeps its value once it is deselected.
- R3: With `mode`=0, `dout_oe` follows the select term. The register loads `din` while `strobe` is 1 and keeps its value once `strobe` is 0.
- R4: While `dout_oe` is 0, `dout` reads 0x00.
- R5: `clear_n`=0 zeroes the data register, unless the register's load enable is active in that cycle. In that case the load takes priority.
- R6: The service-request flag is set, meaning no interrupt, by `clear_n`=0 or by the select term. It is also set after `rst_n`.
- R7: A falling edge on `strobe` clears the flag, and `irq_n` then goes to 0. If a set condition occurs in the same cycle as the falling edge, the set wins.
- R8: `irq_n` is 0 whenever the port is selected, whatever the state of the flag.
- R9: Latency, counted in clock edges after the pin change: a change on a select or mode pin reaches `dout_oe` and `irq_n` 2 edges later. Newly loaded data reaches `dout` 3 edges later. A strobe falling edge reaches `irq_n` 3 edges later.
- R10: With `mode`=0 and `strobe` held at 1, the port acts as a gated buffer. `dout` follows `din` while the port is selected, and reads 0 while it is not.
- R11: After `rst_n`, the outputs are `dout_oe`=0, `dout`=0x00 and `irq_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 8 | Parallel data input |
| sel_lo_n | input | 1 | Select, active low |
| sel_hi | input | 1 | Select, active high |
| mode | input | 1 | 1: output mode, 0: input mode |
| strobe | input | 1 | Load strobe in input mode; its falling edge raises a request |
| clear_n | input | 1 | Active-low register clear and flag set |
| dout | output | 8 | Data output, 0 when not enabled |
| dout_oe | output | 1 | Output enable (stands for the three-state control) |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The two synchronizer stages fix the timing of every result:
- The select and mode terms reach `dout_oe` and `irq_n` on the second edge after a pin change.
- Register contents and strobe-driven requests appear on the third edge, because one more flop stands behind the synchronizer.

Most stimuli are held for four edges before the scoreboard compares, so every result has settled. Dedicated latency steps sample at the falling clock edge, one edge before and exactly at the due edge. This checks that `dout_oe` and `dout` change neither early nor late.

// File: rtl/sport_pkg.sv
package sport_pkg;
  typedef struct packed {
    logic sel_lo_n;
    logic sel_hi;
    logic mode;
    logic strobe;
    logic clear_n;
  } pin_ctrl_t;

  localparam int CTRL_W = $bits(pin_ctrl_t);
endpackage

// File: rtl/sport_sync.sv
module sport_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    always_comb begin
      stg_d[s] = stg_q[s-1];
    end
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign sync_o = stg_q[LAST];
endmodule

// File: rtl/sport_latch.sv
module sport_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic         clr_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;
  logic         upd;

  always_comb begin
    upd = load_en | ~clr_n;
    q_d = q_q;
    if (load_en)     q_d = d_i;
    else if (!clr_n) q_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_q <= '0;
    else if (upd) q_q <= q_d;
  end

  assign q_o = q_q;

  // R2 R3 R5
  load_takes_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> q_o == $past(d_i));

  // R5
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !clr_n) |=> q_o == '0);

  // R2 R3
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && clr_n) |=> $stable(q_o));
endmodule

// File: rtl/sport_srq.sv
module sport_srq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic strobe_s,
  output logic sr_o
);
  logic sr_q, sr_d;
  logic stb_prev_q;
  logic stb_fall;

  always_comb begin
    stb_fall = stb_prev_q & ~strobe_s;
    sr_d     = sr_q;
    if (set_req)       sr_d = 1'b1;
    else if (stb_fall) sr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q       <= 1'b1;
      stb_prev_q <= 1'b0;
    end else begin
      sr_q       <= sr_d;
      stb_prev_q <= strobe_s;
    end
  end

  assign sr_o = sr_q;

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> sr_o);

  // R7
  fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_prev_q && !strobe_s && !set_req) |=> !sr_o);

  // R6 R7
  no_spurious_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sr_o) && !sr_o) |-> $past(stb_prev_q && !strobe_s));
endmodule

// File: rtl/strobed_port.sv
module strobed_port
  import sport_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         sel_lo_n,
  input  logic         sel_hi,
  input  logic         mode,
  input  logic         strobe,
  input  logic         clear_n,
  output logic [W-1:0] dout,
  output logic         dout_oe,
  output logic         irq_n
);
  localparam int BUS_W = W + CTRL_W;

  pin_ctrl_t    ctl_raw, ctl_s;
  logic [W-1:0] din_s;
  logic [W-1:0] latch_q;
  logic         sel_s, load_en, oe, sr;

  always_comb begin
    ctl_raw.sel_lo_n = sel_lo_n;
    ctl_raw.sel_hi   = sel_hi;
    ctl_raw.mode     = mode;
    ctl_raw.strobe   = strobe;
    ctl_raw.clear_n  = clear_n;
  end

  sport_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({din, ctl_raw}),
    .sync_o ({din_s, ctl_s})
  );

  always_comb begin
    sel_s   = ~ctl_s.sel_lo_n & ctl_s.sel_hi;
    load_en = ctl_s.mode ? sel_s : ctl_s.strobe;
    oe      = ctl_s.mode | sel_s;
  end

  sport_latch #(.W(W)) latch_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_en(load_en),
    .clr_n  (ctl_s.clear_n),
    .d_i    (din_s),
    .q_o    (latch_q)
  );

  sport_srq srq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (sel_s | ~ctl_s.clear_n),
    .strobe_s(ctl_s.strobe),
    .sr_o    (sr)
  );

  always_comb begin
    dout_oe = oe;
    dout    = oe ? latch_q : '0;
    irq_n   = ~(~sr | sel_s);
  end

  // R8
  sel_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |-> !irq_n);

  // R2
  out_mode_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_s.mode |-> dout_oe);

  // R4
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> dout == '0);
endmodule

// File: tb/strobed_port_tb_top.sv
`timescale 1ns/1ps
module strobed_port_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] din = '0;
  logic         sel_lo_n = 1'b1, sel_hi = 1'b0, mode = 1'b0;
  logic         strobe = 1'b0, clear_n = 1'b1;
  logic [W-1:0] dout;
  logic         dout_oe, irq_n;

  always #4 clk = ~clk;

  strobed_port #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
    .mode(mode), .strobe(strobe), .clear_n(clear_n),
    .dout(dout), .dout_oe(dout_oe), .irq_n(irq_n)
  );

  typedef struct {
    logic [W-1:0] dout;
    logic         oe;
    logic         irq_n;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // bench model of the requirements
  logic [W-1:0] m_data = '0;
  logic         m_sr = 1'b1;
  logic         m_stb_prev = 1'b0;

  // monitor: pops expected items and compares with the ports
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (dout !== e.dout || dout_oe !== e.oe || irq_n !== e.irq_n) begin
        errors++;
        $display("FAIL %s: dout=%h oe=%b irq_n=%b expected dout=%h oe=%b irq_n=%b",
                 e.tag, dout, dout_oe, irq_n, e.dout, e.oe, e.irq_n);
      end
    end
  end

  task automatic push(input logic [W-1:0] d, input logic o, input logic q, input string tag);
    exp_t e;
    e.dout = d; e.oe = o; e.irq_n = q; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // driver: drives pins, updates the model, waits for settling, pushes expectation
  task automatic apply(input logic [W-1:0] d, input logic lo_n, input logic hi,
                       input logic md, input logic stb, input logic clr, input string tag);
    logic sel, le, oe;
    @(negedge clk);
    din = d; sel_lo_n = lo_n; sel_hi = hi; mode = md; strobe = stb; clear_n = clr;
    sel = !lo_n && hi;
    le  = md ? sel : stb;
    if (le) m_data = d;
    else if (!clr) m_data = '0;
    if (!clr || sel) m_sr = 1'b1;
    else if (m_stb_prev && !stb) m_sr = 1'b0;
    m_stb_prev = stb;
    oe = md || sel;
    repeat (4) @(posedge clk);
    @(negedge clk);
    push(oe ? m_data : '0, oe, !(!m_sr || sel), tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    push('0, 1'b0, 1'b1, "R11 reset state");
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    push('0, 1'b0, 1'b1, "R11 after release");

    // input mode
    apply(8'hA5, 1, 0, 0, 1, 1, "R3 R4 strobe high unselected, output off");
    apply(8'hA5, 1, 0, 0, 0, 1, "R7 strobe fall raises request");
    apply(8'hA5, 0, 1, 0, 0, 1, "R1 R8 select shows held data");
    apply(8'hA5, 1, 0, 0, 0, 1, "R6 select set flag");
    apply(8'h5A, 0, 1, 0, 0, 1, "R3 hold while strobe low");
    apply(8'h5A, 1, 1, 0, 0, 1, "R1 both high not selected");
    apply(8'h5A, 0, 0, 0, 0, 1, "R1 both low not selected");

    // output mode
    apply(8'h77, 1, 0, 1, 0, 1, "R2 oe unselected, no load");
    apply(8'h3C, 0, 1, 1, 0, 1, "R2 load while selected");
    apply(8'hC3, 1, 0, 1, 0, 1, "R2 hold after deselect");
    apply(8'hC3, 1, 0, 1, 0, 0, "R5 clear zeroes register");
    apply(8'h96, 0, 1, 1, 0, 0, "R5 load beats clear");
    apply(8'h96, 1, 0, 1, 0, 1, "R5 clear released, value kept");

    // request flag ordering
    apply(8'h96, 1, 0, 0, 1, 1, "R3 strobe high loads");
    apply(8'h11, 1, 0, 0, 0, 0, "R7 fall with clear: set wins");
    apply(8'h11, 1, 0, 0, 0, 1, "R5 R6 clear release");
    apply(8'h22, 1, 0, 0, 1, 1, "R3 strobe high again");
    apply(8'h22, 1, 0, 0, 0, 1, "R7 fall clears flag");
    apply(8'h22, 1, 0, 0, 0, 0, "R6 clear sets flag");

    // gated buffer
    apply(8'h01, 0, 1, 0, 1, 1, "R10 buffer passes 01");
    apply(8'hFE, 0, 1, 0, 1, 1, "R10 buffer passes FE");
    apply(8'hFE, 1, 0, 0, 1, 1, "R10 buffer off when unselected");

    // R9 cycle-exact latency: select in input mode, strobe high, data 0xFE latched
    @(negedge clk);
    sel_lo_n = 0; sel_hi = 1;
    @(posedge clk); @(negedge clk);
    push('0, 1'b0, 1'b1, "R9 oe not yet after 1 edge");
    @(posedge clk); @(negedge clk);
    push(8'hFE, 1'b1, 1'b0, "R9 oe and irq after 2 edges");
    // output mode, new data
    mode = 1; din = 8'h4B;
    @(posedge clk); @(posedge clk); @(negedge clk);
    push(8'hFE, 1'b1, 1'b0, "R9 data not yet after 2 edges");
    @(posedge clk); @(negedge clk);
    push(8'h4B, 1'b1, 1'b0, "R9 data after 3 edges");

    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule